// File: doc/BRIEF.md
# Precision Time Counter with Alarms, Captures and Periodic Pulses

This block keeps a 64-bit nanosecond time value for packet timestamping. Each enabled clock moves the time forward by a fixed nominal step. A 32-bit fractional accumulator, fed by a software-programmable addend, adds one extra nanosecond whenever it overflows. Software trims the clock rate by nudging the addend up or down, and it can do so at any moment. Two one-shot alarm comparators drive alarm output pins. Up to three fixed-interval generators drive periodic output pins. Two external trigger inputs each capture the time into a capture register of their own.

All state is reached over a plain 32-bit register bus with address, write strobe, read strobe, write data and combinational read data. A write takes effect at the clock edge where the strobe is sampled, and a read returns data in the same cycle. The bus never stalls, so there is no back-pressure. Event flags, an event enable mask and a single interrupt line report triggers, alarms and the first periodic pulse. A parameter picks one of two register-map layouts. The layouts differ only in the base addresses of the four register groups.

Top module: `prec_timer`

## Requirements
- R1: After reset the time is 0, all event flags are 0, the mask is 0, and alarm_out, periodic_out and irq are all low.
- R2: While the run bit (control bit 0) is set, each clock adds NOM_PERIOD to the time. It adds one more whenever the 32-bit accumulator carries out of (accumulator + addend). With addend k·2^28, any 16 consecutive clocks therefore advance the time by 16·NOM_PERIOD + k.
- R3: A write to the time-low register only stages the value. A following write to the time-high register loads both halves into the time at once. With the run bit clear the time holds.
- R4: A read of the time-low register copies the current high half into a shadow. Reads of the time-high register return that shadow, so a low-then-high read pair is coherent.
- R5: Writing an alarm's high word arms it. When an armed alarm sees time ≥ target while running, it disarms and its pulse is high for exactly the next cycle. In that cycle the time equals target + one step, so software programs the wanted time minus one step.
- R6: Control bit 31 inverts alarm_out[0] and control bit 30 inverts alarm_out[1].
- R7: A rising edge on ext_trig[i] copies the current time into capture register i and sets event bit i (bit 0 for trigger 0, bit 1 for trigger 1). The other capture register is not changed.
- R8: The event bits are: 0 trigger 0, 1 trigger 1, 2 alarm 0, 3 alarm 1, 4 periodic output 0. A bit is cleared by writing 1 to it. A set in the same cycle wins over the clear.
- R9: irq is high exactly when some event bit and the matching mask bit are both 1.
- R10: With control bits 0 and 1 both set, periodic_out[i] pulses for one cycle every P cycles, where P is its interval register. When P is 0 the output stays low.
- R11: Writing 0 to the control register stops the time and holds all alarm and periodic outputs low.
- R12: With VARIANT 0 the group bases are control 0x00, alarm 0x40, periodic 0x80 and capture 0xA0. With VARIANT 1 they are 0x80, 0xB8, 0xD0 and 0xE0. Unmapped addresses read 0. Offsets inside a group: control +0 CTRL, +4 EVENT, +8 MASK, +0xC TIME_LO, +0x10 TIME_HI, +0x14 ADDEND; alarm k: +8k HIGH, +8k+4 LOW; periodic i: +4i; capture k: +8k HIGH, +8k+4 LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (latches the time-high shadow on a time-low read) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_trig | input | 2 | External capture triggers, synchronous to clk |
| alarm_out | output | 2 | Alarm pulses after polarity |
| periodic_out | output | NUM_PER | Fixed-interval pulses |
| irq | output | 1 | Masked OR of the event flags |

## Verification
A wrong accumulator or step value shows up as a time difference that is off by a few nanoseconds across a 16-cycle read window, within one window of the fault. A stale shadow or a half-committed time load shows up on the very next register read pair. A comparator or arming fault moves the alarm pulse away from the cycle where the time reads target plus one step, or removes it entirely. A periodic or event-flag fault appears within one interval as a wrong pulse spacing, a wrong flag readback or a wrong irq level.

// File: rtl/prec_timer_pkg.sv
package prec_timer_pkg;
  localparam int TW  = 64;
  localparam int NEV = 5;

  localparam int EV_TRIG0 = 0;
  localparam int EV_TRIG1 = 1;
  localparam int EV_ALM0  = 2;
  localparam int EV_ALM1  = 3;
  localparam int EV_PER0  = 4;

  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_EVENT  = 'h04;
  localparam int OFS_MASK   = 'h08;
  localparam int OFS_TLO    = 'h0C;
  localparam int OFS_THI    = 'h10;
  localparam int OFS_ADDEND = 'h14;

  typedef struct packed {
    logic [7:0] ctl;
    logic [7:0] alm;
    logic [7:0] per;
    logic [7:0] cap;
  } grp_base_t;

  function automatic grp_base_t grp_base(input int variant);
    grp_base_t b;
    if (variant == 0) begin
      b.ctl = 8'h00; b.alm = 8'h40; b.per = 8'h80; b.cap = 8'hA0;
    end else begin
      b.ctl = 8'h80; b.alm = 8'hB8; b.per = 8'hD0; b.cap = 8'hE0;
    end
    return b;
  endfunction
endpackage

// File: rtl/prec_timer_count.sv
module prec_timer_count #(
  parameter int NOM_PERIOD = 8,
  parameter int CW         = 64,
  parameter int FW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [FW-1:0] addend,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] STEP = CW'(NOM_PERIOD);

  logic [FW-1:0] acc_q;
  logic [FW:0]   acc_sum;
  logic [CW-1:0] carry_ext;

  assign acc_sum   = {1'b0, acc_q} + {1'b0, addend};
  assign carry_ext = {{(CW-1){1'b0}}, acc_sum[FW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (run) begin
      acc_q <= acc_sum[FW-1:0];
      count <= count + STEP + carry_ext;
    end
  end
endmodule

// File: rtl/prec_timer_alarm.sv
module prec_timer_alarm #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] count,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [31:0]   wdata,
  output logic [CW-1:0] target,
  output logic          match,
  output logic          hit
);
  logic armed_q;

  assign match = armed_q && run && (count >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target  <= '0;
      armed_q <= 1'b0;
      hit     <= 1'b0;
    end else begin
      hit <= match;
      if (match) armed_q <= 1'b0;
      if (wr_lo) target[31:0] <= wdata;
      if (wr_hi) begin
        target[CW-1:32] <= wdata[CW-33:0];
        armed_q         <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prec_timer_period.sv
module prec_timer_period #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] interval,
  output logic          pulse
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (!run || interval == '0) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (cnt_q >= interval - 1'b1) begin
      cnt_q <= '0;
      pulse <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/prec_timer.sv
module prec_timer
  import prec_timer_pkg::*;
#(
  parameter int VARIANT    = 0,
  parameter int NOM_PERIOD = 8,
  parameter int NUM_PER    = 3,
  parameter int AW         = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [1:0]         ext_trig,
  output logic [1:0]         alarm_out,
  output logic [NUM_PER-1:0] periodic_out,
  output logic               irq
);
  localparam grp_base_t GB = grp_base(VARIANT);
  localparam logic [AW-1:0] A_CTRL = AW'(int'(GB.ctl) + OFS_CTRL);
  localparam logic [AW-1:0] A_EVT  = AW'(int'(GB.ctl) + OFS_EVENT);
  localparam logic [AW-1:0] A_MASK = AW'(int'(GB.ctl) + OFS_MASK);
  localparam logic [AW-1:0] A_TLO  = AW'(int'(GB.ctl) + OFS_TLO);
  localparam logic [AW-1:0] A_THI  = AW'(int'(GB.ctl) + OFS_THI);
  localparam logic [AW-1:0] A_ADD  = AW'(int'(GB.ctl) + OFS_ADDEND);

  logic           te_q, ps_q;
  logic [1:0]     pol_q;
  logic [NEV-1:0] evt_q, mask_q, evt_set, evt_clr;
  logic [31:0]    addend_q, pend_lo_q, shadow_hi_q;
  logic [TW-1:0]  count;
  logic           cnt_load;
  logic           per_run;

  logic [1:0]     alm_wr_lo, alm_wr_hi, alm_match, alm_hit;
  logic [TW-1:0]  alm_tgt [2];
  logic [NUM_PER-1:0] per_wr, per_pulse;
  logic [31:0]    per_q [NUM_PER];
  logic [1:0]     trig_q, trig_edge;
  logic [TW-1:0]  cap_q [2];

  assign cnt_load = bus_we && (bus_addr == A_THI);
  assign per_run  = te_q && ps_q;

  // control, mask, addend, staging and shadow registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q        <= 1'b0;
      ps_q        <= 1'b0;
      pol_q       <= 2'b00;
      mask_q      <= '0;
      addend_q    <= '0;
      pend_lo_q   <= '0;
      shadow_hi_q <= '0;
    end else begin
      if (bus_we && bus_addr == A_CTRL) begin
        te_q     <= bus_wdata[0];
        ps_q     <= bus_wdata[1];
        pol_q[0] <= bus_wdata[31];
        pol_q[1] <= bus_wdata[30];
      end
      if (bus_we && bus_addr == A_MASK) mask_q    <= bus_wdata[NEV-1:0];
      if (bus_we && bus_addr == A_ADD)  addend_q  <= bus_wdata;
      if (bus_we && bus_addr == A_TLO)  pend_lo_q <= bus_wdata;
      if (bus_re && bus_addr == A_TLO)  shadow_hi_q <= count[TW-1:32];
    end
  end

  prec_timer_count #(.NOM_PERIOD(NOM_PERIOD), .CW(TW), .FW(32)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (te_q),
    .addend   (addend_q),
    .load     (cnt_load),
    .load_val ({bus_wdata, pend_lo_q}),
    .count    (count)
  );

  // alarm comparators
  for (genvar k = 0; k < 2; k++) begin : g_alm
    localparam logic [AW-1:0] A_HI = AW'(int'(GB.alm) + 8*k);
    localparam logic [AW-1:0] A_LO = AW'(int'(GB.alm) + 8*k + 4);
    assign alm_wr_hi[k] = bus_we && (bus_addr == A_HI);
    assign alm_wr_lo[k] = bus_we && (bus_addr == A_LO);

    prec_timer_alarm #(.CW(TW)) u_alarm (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (te_q),
      .count  (count),
      .wr_lo  (alm_wr_lo[k]),
      .wr_hi  (alm_wr_hi[k]),
      .wdata  (bus_wdata),
      .target (alm_tgt[k]),
      .match  (alm_match[k]),
      .hit    (alm_hit[k])
    );
    assign alarm_out[k] = alm_hit[k] ^ pol_q[k];
  end

  // fixed-interval generators
  for (genvar i = 0; i < NUM_PER; i++) begin : g_per
    localparam logic [AW-1:0] A_P = AW'(int'(GB.per) + 4*i);
    assign per_wr[i] = bus_we && (bus_addr == A_P);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         per_q[i] <= '0;
      else if (per_wr[i]) per_q[i] <= bus_wdata;
    end

    prec_timer_period #(.PW(32)) u_period (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (per_run),
      .interval (per_q[i]),
      .pulse    (per_pulse[i])
    );
  end
  assign periodic_out = per_pulse;

  // external trigger capture
  for (genvar k = 0; k < 2; k++) begin : g_cap
    assign trig_edge[k] = ext_trig[k] && !trig_q[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig_q[k] <= 1'b0;
        cap_q[k]  <= '0;
      end else begin
        trig_q[k] <= ext_trig[k];
        if (trig_edge[k]) cap_q[k] <= count;
      end
    end
  end

  // event flags: set wins over write-one-to-clear
  always_comb begin
    evt_set = '0;
    evt_set[EV_TRIG0] = trig_edge[0];
    evt_set[EV_TRIG1] = trig_edge[1];
    evt_set[EV_ALM0]  = alm_match[0];
    evt_set[EV_ALM1]  = alm_match[1];
    evt_set[EV_PER0]  = per_pulse[0];
    evt_clr = (bus_we && bus_addr == A_EVT) ? bus_wdata[NEV-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~evt_clr) | evt_set;
  end

  assign irq = |(evt_q & mask_q);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata = {pol_q[0], pol_q[1], 28'd0, ps_q, te_q};
    if (bus_addr == A_EVT)  bus_rdata = 32'(evt_q);
    if (bus_addr == A_MASK) bus_rdata = 32'(mask_q);
    if (bus_addr == A_TLO)  bus_rdata = count[31:0];
    if (bus_addr == A_THI)  bus_rdata = shadow_hi_q;
    if (bus_addr == A_ADD)  bus_rdata = addend_q;
    for (int k = 0; k < 2; k++) begin
      if (bus_addr == AW'(int'(GB.alm) + 8*k))     bus_rdata = alm_tgt[k][TW-1:32];
      if (bus_addr == AW'(int'(GB.alm) + 8*k + 4)) bus_rdata = alm_tgt[k][31:0];
      if (bus_addr == AW'(int'(GB.cap) + 8*k))     bus_rdata = cap_q[k][TW-1:32];
      if (bus_addr == AW'(int'(GB.cap) + 8*k + 4)) bus_rdata = cap_q[k][31:0];
    end
    for (int i = 0; i < NUM_PER; i++) begin
      if (bus_addr == AW'(int'(GB.per) + 4*i)) bus_rdata = per_q[i];
    end
  end
endmodule

// File: rtl/prec_timer_chk.sv
module prec_timer_chk
  import prec_timer_pkg::*;
#(
  parameter int NOM_PERIOD = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           te_q,
  input logic           cnt_load,
  input logic [TW-1:0]  count,
  input logic [1:0]     alm_hit,
  input logic [1:0]     trig_edge,
  input logic [NEV-1:0] evt_q,
  input logic [NEV-1:0] mask_q,
  input logic           irq,
  input logic           per_run,
  input logic           per_pulse0
);
  // R11: a stopped timer keeps its time unless software loads it
  p_time_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!te_q && !cnt_load) |=> $stable(count));

  // R2: a running timer steps by the nominal period or one more
  p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (te_q && !cnt_load) |=> ((count - $past(count)) == TW'(NOM_PERIOD) ||
                             (count - $past(count)) == TW'(NOM_PERIOD + 1)));

  // R5: an alarm pulse comes with its event flag
  p_alarm0_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alm_hit[0] |-> evt_q[EV_ALM0]);
  p_alarm1_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alm_hit[1] |-> evt_q[EV_ALM1]);

  // R7: a trigger edge raises its event flag
  p_trig0_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge[0] |=> evt_q[EV_TRIG0]);
  p_trig1_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge[1] |=> evt_q[EV_TRIG1]);

  // R9: the interrupt needs an enabled and a pending flag
  p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));
  p_irq_needs_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_q != '0));

  // R10: no periodic pulse follows a cycle without run and start
  p_period_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !per_run |=> !per_pulse0);
endmodule

bind prec_timer prec_timer_chk #(.NOM_PERIOD(NOM_PERIOD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .te_q       (te_q),
  .cnt_load   (cnt_load),
  .count      (count),
  .alm_hit    (alm_hit),
  .trig_edge  (trig_edge),
  .evt_q      (evt_q),
  .mask_q     (mask_q),
  .irq        (irq),
  .per_run    (per_run),
  .per_pulse0 (per_pulse[0])
);

// File: tb/prec_timer_test.sv
`timescale 1ns/1ps
module prec_timer_test;
  localparam int NOM = 8;
  localparam int AW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic [1:0]    ext_trig = 2'b00, alarm_out;
  logic [2:0]    periodic_out;
  logic          irq;

  logic [AW-1:0] b1_addr = '0;
  logic          b1_we = 1'b0;
  logic [31:0]   b1_wdata = '0, b1_rdata;
  logic [1:0]    alarm_out1;
  logic [2:0]    periodic_out1;
  logic          irq1;

  prec_timer #(.VARIANT(0), .NOM_PERIOD(NOM), .NUM_PER(3), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
    .alarm_out(alarm_out), .periodic_out(periodic_out), .irq(irq));

  prec_timer #(.VARIANT(1), .NOM_PERIOD(NOM), .NUM_PER(3), .AW(AW)) uut_v1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(b1_addr), .bus_we(b1_we), .bus_re(1'b0),
    .bus_wdata(b1_wdata), .bus_rdata(b1_rdata), .ext_trig(2'b00),
    .alarm_out(alarm_out1), .periodic_out(periodic_out1), .irq(irq1));

  localparam logic [7:0] CTRL = 8'h00, EVT = 8'h04, MASK = 8'h08, TLO = 8'h0C,
                         THI = 8'h10, ADD = 8'h14, A0H = 8'h40, A0L = 8'h44,
                         P0 = 8'h80, P1 = 8'h84, C0H = 8'hA0, C0L = 8'hA4,
                         C1H = 8'hA8, C1L = 8'hAC;

  int nvec = 0, nerr = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_re = 1'b0;
  endtask

  task automatic wr1(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    b1_addr = a; b1_wdata = d; b1_we = 1'b1;
    @(negedge clk);
    b1_we = 1'b0;
  endtask

  task automatic rd1(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    b1_addr = a;
    #1 d = b1_rdata;
  endtask

  task automatic pulse_trig(input int idx);
    @(negedge clk); ext_trig[idx] = 1'b1;
    repeat (2) @(negedge clk);
    ext_trig[idx] = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] a, b, v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    check("R1 alarm_out", 64'(alarm_out), 64'd0);
    check("R1 periodic_out", 64'(periodic_out), 64'd0);
    check("R1 irq", 64'(irq), 64'd0);
    rd(TLO, v); check("R1 time low", 64'(v), 64'd0);
    rd(EVT, v); check("R1 events", 64'(v), 64'd0);
    rd(MASK, v); check("R1 mask", 64'(v), 64'd0);

    // R3 staged load with the timer stopped
    wr(TLO, 32'h89AB_CDEF);
    rd(TLO, v); check("R3 low write stages only", 64'(v), 64'd0);
    wr(THI, 32'h0123_4567);
    rd(TLO, v); check("R3 low after commit", 64'(v), 64'h89AB_CDEF);
    rd(THI, v); check("R3/R4 high after commit", 64'(v), 64'h0123_4567);
    repeat (5) @(negedge clk);
    rd(TLO, v); check("R3 stopped time holds", 64'(v), 64'h89AB_CDEF);

    // R2 addend sweep: 16-cycle windows, k carries per window
    wr(CTRL, 32'h1);
    for (int k = 0; k < 16; k++) begin
      wr(ADD, 32'(k) << 28);
      rd(TLO, a);
      repeat (15) @(negedge clk);
      rd(TLO, b);
      check($sformatf("R2 step addend k=%0d", k), 64'(b - a), 64'(16 * NOM + k));
    end

    // R4 coherent split read across a low-word wrap
    wr(ADD, 32'h0);
    wr(TLO, 32'hFFFF_FFF0);
    wr(THI, 32'h5);
    rd(TLO, a);
    repeat (5) @(negedge clk);
    rd(THI, b);
    check("R4 low of pair", 64'(a), 64'hFFFF_FFF8);
    check("R4 high shadow of pair", 64'(b), 64'h5);

    // R5 alarm: target = wanted - step
    wr(CTRL, 32'h0);
    wr(EVT, 32'h1F);
    wr(TLO, 32'd1000);
    wr(THI, 32'd0);
    wr(A0L, 32'd1000 + 32'(19 * NOM));
    wr(A0H, 32'd0);
    wr(CTRL, 32'h1);
    n = 0;
    while (n < 200) begin
      @(negedge clk); #1;
      if (alarm_out[0]) break;
      n++;
    end
    bus_addr = TLO; #1;
    check("R5 time at alarm pulse", 64'(bus_rdata), 64'd1000 + 64'(20 * NOM));
    @(negedge clk); #1;
    check("R5 pulse lasts one cycle", 64'(alarm_out), 64'd0);
    repeat (5) @(negedge clk); #1;
    check("R5 one-shot no repeat", 64'(alarm_out), 64'd0);
    rd(EVT, v); check("R8 alarm0 flag bit2", 64'(v), 64'h4);
    check("R9 irq masked off", 64'(irq), 64'd0);
    wr(MASK, 32'h4); #1;
    check("R9 irq when enabled", 64'(irq), 64'd1);
    wr(EVT, 32'h4); #1;
    check("R8 write-one clears", 64'(irq), 64'd0);
    rd(EVT, v); check("R8 flags after clear", 64'(v), 64'h0);

    // R6 polarity
    wr(CTRL, 32'h8000_0000); #1;
    check("R6 bit31 inverts alarm0", 64'(alarm_out), 64'h1);
    wr(CTRL, 32'h4000_0000); #1;
    check("R6 bit30 inverts alarm1", 64'(alarm_out), 64'h2);
    wr(CTRL, 32'h0);

    // R7 captures
    wr(MASK, 32'h0);
    wr(TLO, 32'h1234);
    wr(THI, 32'hABC);
    pulse_trig(0);
    rd(C0H, v); check("R7 capture0 high", 64'(v), 64'hABC);
    rd(C0L, v); check("R7 capture0 low", 64'(v), 64'h1234);
    rd(EVT, v); check("R7 trigger0 flag bit0", 64'(v), 64'h1);
    wr(TLO, 32'h55);
    wr(THI, 32'h7);
    pulse_trig(1);
    rd(C1L, v); check("R7 capture1 low", 64'(v), 64'h55);
    rd(C1H, v); check("R7 capture1 high", 64'(v), 64'h7);
    rd(C0L, v); check("R7 capture0 untouched", 64'(v), 64'h1234);
    rd(EVT, v); check("R7 trigger1 flag bit1", 64'(v), 64'h3);
    wr(MASK, 32'h2); #1;
    check("R9 irq from trigger1", 64'(irq), 64'd1);
    wr(EVT, 32'h2); #1;
    check("R9 irq drops, bit0 unmasked", 64'(irq), 64'd0);

    // R10 periodic sweep
    wr(MASK, 32'h0);
    wr(EVT, 32'h1F);
    wr(P1, 32'h0);
    wr(CTRL, 32'h3);
    for (int p = 1; p <= 6; p++) begin
      wr(P0, 32'(p));
      n = 0;
      while (n < 100) begin
        @(negedge clk); #1;
        if (periodic_out[0]) break;
        n++;
      end
      n = 0;
      while (n < 100) begin
        @(negedge clk); #1;
        n++;
        if (periodic_out[0]) break;
      end
      check($sformatf("R10 interval P=%0d", p), 64'(n), 64'(p));
      check("R10 zero interval stays low", 64'(periodic_out[1]), 64'd0);
    end
    rd(EVT, v); check("R10 periodic flag bit4", 64'(v & 32'h10), 64'h10);

    // R11 stop everything
    wr(CTRL, 32'h0);
    rd(TLO, a);
    n = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); #1;
      if (periodic_out != 3'b000 || alarm_out != 2'b00) n++;
    end
    rd(TLO, b);
    check("R11 time frozen", 64'(b), 64'(a));
    check("R11 outputs quiet", 64'(n), 64'd0);

    // R12 alternate layout
    wr1(8'h94, 32'hCAFE_0001);
    rd1(8'h94, v); check("R12 variant1 addend", 64'(v), 64'hCAFE_0001);
    rd1(8'h14, v); check("R12 variant1 old address unmapped", 64'(v), 64'h0);
    wr1(8'hBC, 32'h5);
    wr1(8'hB8, 32'h9);
    rd1(8'hB8, v); check("R12 variant1 alarm0 high", 64'(v), 64'h9);
    rd1(8'hBC, v); check("R12 variant1 alarm0 low", 64'(v), 64'h5);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule